// File: doc/BRIEF.md
# Bidirectional Latched/Registered Bus Transceiver

This block joins two data ports, A and B, that are each 18 bits wide by default. One path carries data from A to B and a second path carries data from B to A. Each path has one storage element that can work in three ways. It can be transparent, so the output follows the input in the same cycle. It can hold a stored value. It can capture the input on a rising edge of that path's own strobe. Each path also has its own output enable, latch enable, strobe and strobe enable.

Real three-state pins are not synthesizable in a core, so each port is modelled with three signals: an input bus, an output bus and a drive-enable flag. Outer pad logic turns these into a true three-state pin. The system clock `clk` samples every control input. A synchronous active-high `rst` clears both stores to zero. While `rst` is high, both drive enables are low whatever the other control inputs are.

Top module: `bus_xcvr`

## Requirements
- R1: While `rst` is high, `a_drive` and `b_drive` are both 0, whatever the enables and data inputs are.
- R2: After `rst` is released, each store holds zero. With its latch enable low and no capture, a path outputs all zeros.
- R3: Outside reset, a port's drive flag is 1 when its path's active-low output enable is 0, and 0 when that enable is 1.
- R4: When a path's latch enable is 1, the path's output equals its input in the same cycle, with no clock edge needed.
- R5: When a path's latch enable falls, the path keeps the input value sampled at the last `clk` edge where the latch enable was 1.
- R6: With the latch enable at 0, a strobe rise loads the input sampled at edge n into the store, and the output shows it from edge n onward. A strobe rise means the strobe is sampled 0 at one `clk` edge and 1 at the next edge n. The active-low strobe enable must be 0 at edge n.
- R7: A strobe rise while the strobe enable is 1 leaves the stored value unchanged.
- R8: While the latch enable is 0 and the strobe stays at 0 or stays at 1, the output does not change, even when the input changes.
- R9: A strobe that is already 1 when reset is released does not count as a rise. It must be sampled 0 after reset before a capture can happen.
- R10: The two paths are independent. The A-to-B controls never change `a_out`, and the B-to-A controls never change `b_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all controls |
| rst | input | 1 | Synchronous active-high reset; forces both ports undriven |
| a_in | input | DATA_W | Value seen on port A |
| a_out | output | DATA_W | Value the B-to-A path offers to port A |
| a_drive | output | 1 | 1 when port A is driven |
| b_in | input | DATA_W | Value seen on port B |
| b_out | output | DATA_W | Value the A-to-B path offers to port B |
| b_drive | output | 1 | 1 when port B is driven |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable, 1 = transparent |
| ab_stb | input | 1 | A-to-B capture strobe |
| ab_stb_en_n | input | 1 | A-to-B strobe enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, 1 = transparent |
| ba_stb | input | 1 | B-to-A capture strobe |
| ba_stb_en_n | input | 1 | B-to-A strobe enable, active low |

## Verification
The properties assume that every control and data input is stable around each rising edge of `clk`. They also assume that a strobe is slow enough for `clk` to see both its low level and its high level. The capture and hold properties only apply once at least two edges have passed without reset, because the strobe history is needed to tell a real rise apart. The stimulus changes inputs one time unit after a rising edge of `clk`. Each strobe level is held for at least one full `clk` period. Reset is held for several cycles before it is released.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int DEF_DATA_W = 18;

    typedef struct packed {
        logic oe_n;
        logic le;
        logic stb;
        logic stb_en_n;
    } dir_ctrl_t;

    typedef enum logic [1:0] {
        MODE_PASS = 2'd0,
        MODE_HOLD = 2'd1,
        MODE_LOAD = 2'd2
    } store_mode_e;

    function automatic store_mode_e pick_mode(input logic le,
                                              input logic rise,
                                              input logic en_n);
        if (le)
            return MODE_PASS;
        else if (rise && !en_n)
            return MODE_LOAD;
        else
            return MODE_HOLD;
    endfunction

endpackage

// File: rtl/xcvr_edge.sv
module xcvr_edge (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    output logic rise
);
    logic stb_q;

    always_ff @(posedge clk) begin
        if (rst)
            stb_q <= 1'b1;
        else
            stb_q <= stb;
    end

    assign rise = stb & ~stb_q;

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
    import xcvr_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din,
    input  dir_ctrl_t         ctrl,
    output logic [DATA_W-1:0] dout,
    output logic              drive
);
    logic              rise;
    logic [DATA_W-1:0] store_q;
    store_mode_e       mode;

    xcvr_edge edge_i (
        .clk  (clk),
        .rst  (rst),
        .stb  (ctrl.stb),
        .rise (rise)
    );

    assign mode = pick_mode(ctrl.le, rise, ctrl.stb_en_n);

    always_ff @(posedge clk) begin
        if (rst)
            store_q <= '0;
        else if (mode != MODE_HOLD)
            store_q <= din;
    end

    assign dout  = ctrl.le ? din : store_q;
    assign drive = ~ctrl.oe_n & ~rst;

    logic [1:0] live_cnt;
    always_ff @(posedge clk) begin
        if (rst)
            live_cnt <= '0;
        else if (live_cnt != 2'd3)
            live_cnt <= live_cnt + 2'd1;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) && !ctrl.le |-> dout == '0); // R2

    AST_LATCH_KEEPS: assert property (@(posedge clk) disable iff (rst)
        live_cnt >= 2'd1 && $fell(ctrl.le) |-> dout == $past(din)); // R5

    AST_RISE_LOADS: assert property (@(posedge clk) disable iff (rst)
        live_cnt >= 2'd2 && !ctrl.le && !$past(ctrl.le) && !$past(ctrl.stb_en_n)
        && $past(ctrl.stb) && !$past(ctrl.stb, 2) |-> dout == $past(din)); // R6

    AST_NO_RISE_STABLE: assert property (@(posedge clk) disable iff (rst)
        live_cnt >= 2'd2 && !ctrl.le && !$past(ctrl.le)
        && ($past(ctrl.stb_en_n) || !$past(ctrl.stb) || $past(ctrl.stb, 2))
        |-> $stable(dout)); // R8

endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr
    import xcvr_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] a_in,
    output logic [DATA_W-1:0] a_out,
    output logic              a_drive,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W-1:0] b_out,
    output logic              b_drive,
    input  logic              ab_oe_n,
    input  logic              ab_le,
    input  logic              ab_stb,
    input  logic              ab_stb_en_n,
    input  logic              ba_oe_n,
    input  logic              ba_le,
    input  logic              ba_stb,
    input  logic              ba_stb_en_n
);
    localparam int N_DIR = 2;

    logic [DATA_W-1:0] src   [N_DIR];
    logic [DATA_W-1:0] dst   [N_DIR];
    logic              drv   [N_DIR];
    dir_ctrl_t         ctl   [N_DIR];

    assign src[0] = a_in;
    assign src[1] = b_in;
    assign ctl[0] = '{oe_n: ab_oe_n, le: ab_le, stb: ab_stb, stb_en_n: ab_stb_en_n};
    assign ctl[1] = '{oe_n: ba_oe_n, le: ba_le, stb: ba_stb, stb_en_n: ba_stb_en_n};

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        xcvr_path #(.DATA_W(DATA_W)) path_i (
            .clk   (clk),
            .rst   (rst),
            .din   (src[d]),
            .ctrl  (ctl[d]),
            .dout  (dst[d]),
            .drive (drv[d])
        );
    end

    assign b_out   = dst[0];
    assign b_drive = drv[0];
    assign a_out   = dst[1];
    assign a_drive = drv[1];

    AST_RESET_HIZ: assert property (@(posedge clk)
        rst |-> !a_drive && !b_drive); // R1

endmodule

// File: tb/bus_xcvr_tb_top.sv
module bus_xcvr_tb_top;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_drive, b_drive;
    logic         ab_oe_n = 1'b0, ab_le = 1'b0, ab_stb = 1'b0, ab_stb_en_n = 1'b0;
    logic         ba_oe_n = 1'b0, ba_le = 1'b0, ba_stb = 1'b0, ba_stb_en_n = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bus_xcvr #(.DATA_W(W)) dut_i (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
        .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
        .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_stb(ab_stb), .ab_stb_en_n(ab_stb_en_n),
        .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_stb(ba_stb), .ba_stb_en_n(ba_stb_en_n)
    );

    function automatic logic [W-1:0] pat(input int k);
        logic [W-1:0] v;
        v = W'(k * 32'h0F3C5) ^ W'(32'h2AAAA >> (k % 5));
        return v;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic put(input int d, input logic [W-1:0] v, input logic oe_n,
                       input logic le, input logic stb, input logic en_n);
        if (d == 0) begin
            a_in = v; ab_oe_n = oe_n; ab_le = le; ab_stb = stb; ab_stb_en_n = en_n;
        end else begin
            b_in = v; ba_oe_n = oe_n; ba_le = le; ba_stb = stb; ba_stb_en_n = en_n;
        end
    endtask

    function automatic logic [W-1:0] out_of(input int d);
        return (d == 0) ? b_out : a_out;
    endfunction

    function automatic logic drv_of(input int d);
        return (d == 0) ? b_drive : a_drive;
    endfunction

    task automatic run_dir(input int d);
        int o;
        logic [W-1:0] held;
        o = 1 - d;
        // reset with enables asserted
        rst = 1'b1;
        put(d, pat(1), 1'b0, 1'b1, 1'b0, 1'b0);
        put(o, pat(2), 1'b0, 1'b1, 1'b0, 1'b0);
        step(); step(); step();
        chk("R1 drive in reset", {17'b0, drv_of(d)}, '0);
        chk("R1 other drive in reset", {17'b0, drv_of(o)}, '0);
        put(d, pat(3), 1'b0, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        step();
        chk("R2 cleared store", out_of(d), '0);
        chk("R3 drive on oe_n=0", {17'b0, drv_of(d)}, 18'd1);
        put(d, pat(3), 1'b1, 1'b0, 1'b0, 1'b0);
        #1;
        chk("R3 no drive on oe_n=1", {17'b0, drv_of(d)}, '0);
        // transparent sweep, other path transparent too
        for (int k = 0; k < 16; k++) begin
            put(d, pat(k), 1'b0, 1'b1, 1'b0, 1'b0);
            #1;
            chk("R4 transparent", out_of(d), pat(k));
            chk("R10 other path untouched", out_of(o), pat(2));
        end
        put(d, '1, 1'b0, 1'b1, 1'b0, 1'b0); #1;
        chk("R4 all ones", out_of(d), '1);
        // latch close
        put(d, pat(20), 1'b0, 1'b1, 1'b0, 1'b0);
        step();
        put(d, pat(21), 1'b0, 1'b0, 1'b0, 1'b0);
        #1;
        chk("R5 latch closes", out_of(d), pat(20));
        for (int k = 0; k < 4; k++) begin
            put(d, pat(22 + k), 1'b0, 1'b0, 1'b0, 1'b0);
            step();
            chk("R8 hold strobe low", out_of(d), pat(20));
        end
        // clocked captures over several patterns
        for (int k = 0; k < 6; k++) begin
            put(d, pat(30 + k), 1'b0, 1'b0, 1'b1, 1'b0);
            step();
            chk("R6 capture on rise", out_of(d), pat(30 + k));
            put(d, pat(40 + k), 1'b0, 1'b0, 1'b1, 1'b0);
            step();
            chk("R8 hold strobe high", out_of(d), pat(30 + k));
            put(d, pat(40 + k), 1'b0, 1'b0, 1'b0, 1'b0);
            step();
            chk("R8 hold after strobe fall", out_of(d), pat(30 + k));
        end
        held = pat(35);
        // gated rise
        put(d, pat(50), 1'b0, 1'b0, 1'b1, 1'b1);
        step();
        chk("R7 gated rise ignored", out_of(d), held);
        put(d, pat(50), 1'b0, 1'b0, 1'b1, 1'b0);
        step();
        chk("R7 enable without rise", out_of(d), held);
        put(d, pat(50), 1'b0, 1'b0, 1'b0, 1'b0);
        step();
        put(d, pat(50), 1'b0, 1'b0, 1'b1, 1'b0);
        step();
        chk("R6 capture after re-enable", out_of(d), pat(50));
        chk("R10 other path untouched", out_of(o), pat(2));
        // strobe high across reset
        rst = 1'b1;
        put(d, pat(60), 1'b0, 1'b0, 1'b1, 1'b0);
        step(); step();
        rst = 1'b0;
        step(); step();
        chk("R9 no rise at reset release", out_of(d), '0);
        put(d, pat(60), 1'b0, 1'b0, 1'b0, 1'b0);
        step();
        put(d, pat(61), 1'b0, 1'b0, 1'b1, 1'b0);
        step();
        chk("R9 rise after low sample", out_of(d), pat(61));
    endtask

    initial begin
        #800000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step();
        run_dir(0);
        run_dir(1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule